// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the program counter of a small 32-bit RISC core and works out, every clock, where the next fetch comes from. It takes the instruction word that was fetched at the current PC and the two source-register values read for it. From these it selects one of four successors:

- the plain sequential address;
- a PC-relative branch target, used when a compare of the two registers succeeds;
- an absolute target built inside the current 256 MB region;
- an address taken straight from a register.

For a call-style jump, the block also raises a write request toward register 31. That request carries the return address, which is the address of the instruction after the call. The core can hold the unit with a stall input. While stalled, the PC freezes and no link write is issued. Instruction memory and the register file sit outside the block.

Top module: `pc_sequencer`

## Requirements
- R1: A synchronous, active-high `rst` sets `pc` to 0 at the next rising edge. While `rst` is high, `link_we` is 0 whatever the instruction.
- R2: When no control transfer is taken, `pc` becomes `pc`+4 at the next edge. This covers every opcode (bits 31:26) other than 0x02, 0x03, 0x04 and 0x05, and every opcode-0 word whose function field (bits 5:0) is not 0x08.
- R3: Opcode 0x04 (branch-if-equal) with `rs_val` == `rt_val` loads `pc`+4 plus the sign-extended 16-bit offset (bits 15:0) times 4. Otherwise it advances to `pc`+4.
- R4: Opcode 0x05 (branch-if-different) with `rs_val` != `rt_val` loads the same PC-relative target as R3. Otherwise it advances to `pc`+4.
- R5: Opcode 0x02 (jump) loads a target made of bits 31:28 of `pc`+4, then the 26-bit index (bits 25:0), then two zero bits.
- R6: Opcode 0x03 (jump-and-link) loads the R5 target. In the same cycle it drives `link_we` high with `link_data` = `pc`+4, which is the value destined for register 31.
- R7: Opcode 0 with function field 0x08 (register jump) loads `pc` with `rs_val` unchanged.
- R8: While `stall` is high, `pc` keeps its value and `link_we` stays 0. `rst` takes priority over `stall`.
- R9: Negative branch offsets move the PC backwards. A jump placed at the last word of a region takes its upper bits from `pc`+4, so the target lies in the following region.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Holds the PC and blocks the link write |
| instr | input | 32 | Instruction word fetched at `pc` |
| rs_val | input | 32 | Value of the first source register |
| rt_val | input | 32 | Value of the second source register |
| pc | output | 32 | Current program counter |
| link_we | output | 1 | Write request for register 31 |
| link_data | output | 32 | Return address (`pc`+4) |

## Verification
The checker tests every cycle for the following:
- the PC step for each flow class (sequential, branch, jump, register jump);
- that the branch decision agrees with the register compare;
- that jump targets keep the upper bits of `pc`+4;
- that the link write and the return address go together;
- the stall freeze and the reset value.

Only the bench's scenarios show the end-to-end paths. These are the backward branch, the jump from the last word of a region into the next one, and a reset landing in the middle of a run.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam logic [5:0] OP_SPECIAL = 6'h00;
  localparam logic [5:0] OP_JUMP    = 6'h02;
  localparam logic [5:0] OP_JLINK   = 6'h03;
  localparam logic [5:0] OP_BEQ     = 6'h04;
  localparam logic [5:0] OP_BNE     = 6'h05;
  localparam logic [5:0] FN_REGJMP  = 6'h08;

  typedef enum logic [1:0] {
    FLOW_SEQ  = 2'd0,
    FLOW_BR   = 2'd1,
    FLOW_ABS  = 2'd2,
    FLOW_REG  = 2'd3
  } flow_e;

  typedef struct packed {
    logic beq;
    logic bne;
    logic jmp;
    logic jal;
    logic jr;
  } ctl_t;
endpackage

// File: rtl/pcs_decode.sv
module pcs_decode
  import pcs_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctl_t       ctl
);
  always_comb begin
    ctl     = '0;
    ctl.beq = (opcode == OP_BEQ);
    ctl.bne = (opcode == OP_BNE);
    ctl.jmp = (opcode == OP_JUMP);
    ctl.jal = (opcode == OP_JLINK);
    ctl.jr  = (opcode == OP_SPECIAL) && (funct == FN_REGJMP);
  end
endmodule

// File: rtl/pcs_resolve.sv
module pcs_resolve
  import pcs_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  ctl_t            ctl,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  output logic            br_taken,
  output flow_e           flow
);
  logic same;
  assign same     = (rs_val == rt_val);
  assign br_taken = (ctl.beq && same) || (ctl.bne && !same);

  always_comb begin
    if (ctl.jr)                  flow = FLOW_REG;
    else if (ctl.jmp || ctl.jal) flow = FLOW_ABS;
    else if (br_taken)           flow = FLOW_BR;
    else                         flow = FLOW_SEQ;
  end
endmodule

// File: rtl/pcs_target.sv
module pcs_target
  import pcs_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int IDX_W = 26
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [IMM_W-1:0] offset,
  input  logic [IDX_W-1:0] index,
  input  logic [XLEN-1:0]  rs_val,
  input  flow_e            flow,
  output logic [XLEN-1:0]  pc_plus4,
  output logic [XLEN-1:0]  next_pc
);
  localparam int REGION_W = XLEN - IDX_W - 2;
  localparam int EXT_W    = XLEN - IMM_W - 2;

  function automatic logic [XLEN-1:0] step_word(input logic [XLEN-1:0] a);
    return a + XLEN'(4);
  endfunction

  function automatic logic [XLEN-1:0] rel_target(input logic [XLEN-1:0] base,
                                                 input logic [IMM_W-1:0] off);
    logic [XLEN-1:0] disp;
    disp = {{EXT_W{off[IMM_W-1]}}, off, 2'b00};
    return base + disp;
  endfunction

  function automatic logic [XLEN-1:0] region_target(input logic [XLEN-1:0] base,
                                                    input logic [IDX_W-1:0] idx);
    return {base[XLEN-1 -: REGION_W], idx, 2'b00};
  endfunction

  assign pc_plus4 = step_word(pc);

  always_comb begin
    unique case (flow)
      FLOW_BR:  next_pc = rel_target(pc_plus4, offset);
      FLOW_ABS: next_pc = region_target(pc_plus4, index);
      FLOW_REG: next_pc = rs_val;
      default:  next_pc = pc_plus4;
    endcase
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcs_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int IDX_W = 26
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stall,
  input  logic [XLEN-1:0] instr,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  output logic [XLEN-1:0] pc,
  output logic            link_we,
  output logic [XLEN-1:0] link_data
);
  ctl_t            ctl;
  flow_e           flow;
  logic            br_taken;
  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] pc_plus4;
  logic [XLEN-1:0] next_pc;

  // named events for the checker
  logic is_seq, is_abs, is_jal, is_jr;
  assign is_seq = (flow == FLOW_SEQ);
  assign is_abs = (flow == FLOW_ABS);
  assign is_jal = ctl.jal;
  assign is_jr  = ctl.jr;

  pcs_decode u_decode (
    .opcode (instr[XLEN-1 -: 6]),
    .funct  (instr[5:0]),
    .ctl    (ctl)
  );

  pcs_resolve #(.XLEN(XLEN)) u_resolve (
    .ctl      (ctl),
    .rs_val   (rs_val),
    .rt_val   (rt_val),
    .br_taken (br_taken),
    .flow     (flow)
  );

  pcs_target #(.XLEN(XLEN), .IMM_W(IMM_W), .IDX_W(IDX_W)) u_target (
    .pc       (pc_q),
    .offset   (instr[IMM_W-1:0]),
    .index    (instr[IDX_W-1:0]),
    .rs_val   (rs_val),
    .flow     (flow),
    .pc_plus4 (pc_plus4),
    .next_pc  (next_pc)
  );

  always_ff @(posedge clk) begin
    if (rst)         pc_q <= '0;
    else if (!stall) pc_q <= next_pc;
  end

  assign pc        = pc_q;
  assign link_we   = ctl.jal && !stall && !rst;
  assign link_data = pc_plus4;
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int IDX_W = 26
) (
  input logic            clk,
  input logic            rst,
  input logic            stall,
  input logic [XLEN-1:0] instr,
  input logic [XLEN-1:0] rs_val,
  input logic [XLEN-1:0] rt_val,
  input logic [XLEN-1:0] pc,
  input logic            link_we,
  input logic [XLEN-1:0] link_data,
  input logic            is_seq,
  input logic            is_abs,
  input logic            is_jal,
  input logic            is_jr,
  input logic            br_taken
);
  localparam int REGION_W = XLEN - IDX_W - 2;
  localparam int EXT_W    = XLEN - IMM_W - 2;

  logic [5:0] op;
  assign op = instr[XLEN-1 -: 6];

  assert_reset_pc_R1: assert property (@(posedge clk) rst |=> pc == '0);
  assert_reset_nolink_R1: assert property (@(posedge clk) rst |-> !link_we);

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
    (is_seq && !stall) |=> pc == $past(pc) + XLEN'(4));

  assert_branch_disp_R3: assert property (@(posedge clk) disable iff (rst)
    (br_taken && !stall) |=>
      (pc - $past(pc) - XLEN'(4)) == {{EXT_W{$past(instr[IMM_W-1])}}, $past(instr[IMM_W-1:0]), 2'b00});

  assert_beq_decide_R3: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h04) |-> (br_taken == (rs_val == rt_val)));

  assert_bne_decide_R4: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h05) |-> (br_taken == (rs_val != rt_val)));

  assert_region_keep_R5: assert property (@(posedge clk) disable iff (rst)
    (is_abs && !stall) |=>
      (pc[XLEN-1 -: REGION_W] == $past(link_data[XLEN-1 -: REGION_W])) &&
      (pc[XLEN-REGION_W-1:0] == {$past(instr[IDX_W-1:0]), 2'b00}));

  assert_link_pair_R6: assert property (@(posedge clk) disable iff (rst)
    (is_jal && !stall) |-> (link_we && link_data == pc + XLEN'(4)));

  assert_link_only_call_R6: assert property (@(posedge clk) disable iff (rst)
    link_we |-> is_jal);

  assert_regjump_R7: assert property (@(posedge clk) disable iff (rst)
    (is_jr && !stall) |=> pc == $past(rs_val));

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(pc));

  assert_stall_nolink_R8: assert property (@(posedge clk) disable iff (rst)
    stall |-> !link_we);
endmodule

bind pc_sequencer pcs_checker #(.XLEN(XLEN), .IMM_W(IMM_W), .IDX_W(IDX_W)) u_pcs_checker (
  .clk       (clk),
  .rst       (rst),
  .stall     (stall),
  .instr     (instr),
  .rs_val    (rs_val),
  .rt_val    (rt_val),
  .pc        (pc),
  .link_we   (link_we),
  .link_data (link_data),
  .is_seq    (is_seq),
  .is_abs    (is_abs),
  .is_jal    (is_jal),
  .is_jr     (is_jr),
  .br_taken  (br_taken)
);

// File: tb/test_pc_sequencer.sv
`timescale 1ns/1ps
module test_pc_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall = 1'b0;
  logic [31:0] instr = 32'h0;
  logic [31:0] rs_val = 32'h0;
  logic [31:0] rt_val = 32'h0;
  logic [31:0] pc;
  logic        link_we;
  logic [31:0] link_data;

  int checks = 0;
  int fails  = 0;
  logic [31:0] model_pc = 32'h0;

  always #5 clk = ~clk;

  pc_sequencer i_pc_sequencer (
    .clk(clk), .rst(rst), .stall(stall), .instr(instr),
    .rs_val(rs_val), .rt_val(rt_val),
    .pc(pc), .link_we(link_we), .link_data(link_data)
  );

  // behavioural reference: what the next PC should be
  function automatic logic [31:0] ref_next(input logic [31:0] cur, input logic [31:0] w,
                                           input logic [31:0] a, input logic [31:0] b);
    int unsigned op;
    int signed   off;
    logic [31:0] seq;
    op  = w >> 26;
    off = $signed(w[15:0]);
    seq = cur + 32'd4;
    if (op == 4 && a == b)               return seq + 32'(off * 4);
    if (op == 5 && a != b)               return seq + 32'(off * 4);
    if (op == 2 || op == 3)              return (seq & 32'hF000_0000) | ((w & 32'h03FF_FFFF) * 4);
    if (op == 0 && (w & 32'h3F) == 8)    return a;
    return seq;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  // one clock: drive, check link outputs, clock, check PC
  task automatic step(input string req, input logic r, input logic s,
                      input logic [31:0] w, input logic [31:0] a, input logic [31:0] b);
    logic exp_we;
    @(negedge clk);
    rst = r; stall = s; instr = w; rs_val = a; rt_val = b;
    #1;
    exp_we = (!r && !s && (w >> 26) == 3);
    check({req, " link_we"}, {31'b0, link_we}, {31'b0, exp_we});
    if (exp_we) check({req, " link_data"}, link_data, model_pc + 32'd4);
    if (r)       model_pc = 32'h0;
    else if (!s) model_pc = ref_next(model_pc, w, a, b);
    @(posedge clk);
    #1;
    check({req, " pc"}, pc, model_pc);
  endtask

  localparam logic [31:0] NOP = 32'h0000_0000;

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    step("R1 reset with jal present", 1, 0, 32'h0C00_0010, 0, 0);
    step("R1 reset held", 1, 0, NOP, 0, 0);
    step("R2 seq", 0, 0, NOP, 0, 0);
    step("R2 seq", 0, 0, NOP, 0, 0);
    step("R2 other R-type add", 0, 0, 32'h0232_4020, 5, 6);
    step("R2 unknown opcode", 0, 0, 32'hFC00_0008, 1, 2);
    step("R3 beq taken fwd", 0, 0, {6'h04, 10'h0, 16'd3}, 32'h55, 32'h55);
    step("R3 beq not taken", 0, 0, {6'h04, 10'h0, 16'd3}, 32'h55, 32'h56);
    step("R4 bne taken back R9", 0, 0, {6'h05, 10'h0, 16'hFFFE}, 1, 2);
    step("R4 bne not taken", 0, 0, {6'h05, 10'h0, 16'hFFFE}, 7, 7);
    step("R5 jump", 0, 0, {6'h02, 26'h012_3456}, 0, 0);
    step("R6 jal", 0, 0, {6'h03, 26'h000_0100}, 0, 0);
    step("R7 jr to region end", 0, 0, 32'h03E0_0008, 32'h0FFF_FFFC, 0);
    step("R9 jump crosses region", 0, 0, {6'h02, 26'h000_0040}, 0, 0);
    step("R6 jal high region", 0, 0, {6'h03, 26'h3FF_FFFF}, 0, 0);
    step("R8 stall with jal", 0, 1, {6'h03, 26'h000_0001}, 0, 0);
    step("R8 stall with beq", 0, 1, {6'h04, 10'h0, 16'd8}, 3, 3);
    step("R8 stall with jr", 0, 1, 32'h03E0_0008, 32'h1234_5678, 0);
    step("R2 after stall", 0, 0, NOP, 0, 0);
    step("R7 jr", 0, 0, 32'h0120_0008, 32'h0040_0000, 0);
    step("R3 beq negative R9", 0, 0, {6'h04, 10'h0, 16'h8000}, 9, 9);
    step("R8 reset beats stall R1", 1, 1, NOP, 0, 0);
    step("R2 after mid reset", 0, 0, NOP, 0, 0);
    step("R6 jal from low pc", 0, 0, {6'h03, 26'h000_0020}, 0, 0);
    for (int k = 0; k < 8; k++)
      step("R2 run", 0, 0, NOP, k, k + 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule